// File: doc/BRIEF.md
# Asynchronous Serial Channel

This block is a full-duplex asynchronous serial port with a small byte-wide register window. Software programs the line format and the bit rate, writes a byte for transmission, and clears a status flag to release it. The block shifts the character out on `txd` and reassembles characters arriving on `rxd`. Status flags report the state of the transmit holding register, of the receive holding register and of line errors. Four interrupt request lines are driven from these flags, each gated by an enable bit in the control register.

The line format selects 7 or 8 data bits, an optional even or odd parity bit, and one or two stop bits. Every frame begins with one low start bit and sends data least significant bit first. A single prescaler divides the system clock by the selected divider times the bit-rate value, giving a sub-bit tick, and each bit lasts 32 such ticks. The receiver re-aligns its tick count on each start edge and samples every bit near its middle.

Top module: `sci_uart_top`

## Requirements
- R1: Registers sit at byte offsets 0 mode, 1 bit-rate, 2 control, 3 transmit data, 4 status, 5 receive data. After reset they read 0x00, 0xFF, 0x00, 0xFF, 0x84 and 0x00.
- R2: A transmitted frame is a low start bit, then the data least significant bit first, then an optional parity bit, then one or two high stop bits. The line idles high. Mode bit 6 set gives 7 data bits (clear gives 8). Mode bit 5 adds parity, which is odd when mode bit 4 is set and even when it is clear. Mode bit 3 adds a second stop bit.
- R3: One bit lasts 32 × D × B system clocks. B is the bit-rate register, and D is 1, 4, 16 or 64 for mode bits [1:0] = 0, 1, 2 or 3. The receiver decodes frames sent at that bit time.
- R4: A transmission starts only while control bit 5 is set and status bit 7 (transmit empty) is 0. Status bit 7 returns to 1 when the byte is taken into the shifter, which happens within two clocks of both conditions holding. With control bit 5 clear, `txd` stays high and bit 7 stays 0.
- R5: Status bit 2 (transmit end) is set when a frame finishes while bit 7 is 1. It is cleared whenever bit 7 is cleared.
- R6: With control bit 4 set, a received character is written to the receive data register (bit 7 reads 0 in 7-bit mode) and status bit 6 (receive full) is set. With control bit 4 clear, incoming frames change neither the status register nor the receive data register.
- R7: A character that completes while status bit 6 is 1 sets status bit 5 (overrun) and leaves the receive data register unchanged.
- R8: A received parity bit that disagrees with the selected parity sets status bit 3. A low first stop bit sets status bit 4.
- R9: Writing 0 to status bits 7, 6, 5, 4 or 3 clears that bit. Writing 1 to any status bit has no effect, and bit 2 cannot be written.
- R10: `irq_tx_empty` = status bit 7 AND control bit 7. `irq_rx_full` = status bit 6 AND control bit 6. `irq_rx_err` = (status bit 5 OR 4 OR 3) AND control bit 6. `irq_tx_done` = status bit 2 AND control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |
| irq_tx_done | output | 1 | Transmit-end interrupt request |

## Verification
The bench builds the block with its default 32-tick bit and a sampling point at tick 16. It then varies the line format and the bit time at run time through the mode and bit-rate registers. The vector table covers dividers 1, 4 and 16 with bit-rate values 1 and 2, giving bits of 32 to 512 clocks. That keeps every frame format, including 7-bit data with parity and two stop bits, within a short run. The same table drives the transmitter and the receiver, so both are checked against the bench's own frame model. Directed tests then cover overrun, parity and stop-bit errors, disabled directions and the status write semantics.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int REG_W     = 8;
    localparam int FRAME_MAX = 12;                       // start + 8 data + parity + 2 stop
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int PRESC_W   = 14;                       // holds 64 * 255

    typedef enum logic [2:0] {
        OFS_MODE = 3'd0,
        OFS_RATE = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_TDAT = 3'd3,
        OFS_STAT = 3'd4,
        OFS_RDAT = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        logic       seven;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic [1:0] div_sel;
    } line_cfg_t;

    localparam logic [REG_W-1:0] STAT_RESET = 8'h84;

    // parity bit value that makes the selected parity hold
    function automatic logic parity_of(input logic seven, input logic odd,
                                       input logic [REG_W-1:0] d);
        logic [REG_W-1:0] v;
        v = seven ? {1'b0, d[REG_W-2:0]} : d;
        return (^v) ^ odd;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input logic seven, input logic par_en,
                                                   input logic two_stop);
        return LEN_W'(seven ? 8 : 9) + LEN_W'(par_en) + LEN_W'(two_stop ? 2 : 1);
    endfunction

    // bit 0 goes on the line first; unused upper positions stay high (stop level)
    function automatic logic [FRAME_MAX-1:0] frame_of(input logic seven, input logic par_en,
                                                      input logic odd, input logic [REG_W-1:0] d);
        logic [FRAME_MAX-1:0] f;
        int nd;
        f    = '1;
        f[0] = 1'b0;
        nd   = seven ? REG_W - 1 : REG_W;
        for (int i = 0; i < REG_W; i++)
            if (i < nd) f[1 + i] = d[i];
        if (par_en) f[1 + nd] = parity_of(seven, odd, d);
        return f;
    endfunction

endpackage

// File: rtl/sci_rate_gen.sv
module sci_rate_gen
    import sci_pkg::*;
#(
    parameter int CNT_W = PRESC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       div_sel,
    input  logic [REG_W-1:0] rate,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;

    always_comb begin
        case (div_sel)
            2'd0:    period = CNT_W'(rate);
            2'd1:    period = CNT_W'(rate) << 2;
            2'd2:    period = CNT_W'(rate) << 4;
            default: period = CNT_W'(rate) << 6;
        endcase
    end

    // a period of 0 or 1 ticks every clock
    assign tick = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assert_prescale_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (period > CNT_W'(1) && !tick) |=> (cnt_q != '0));

endmodule

// File: rtl/sci_tx.sv
module sci_tx
    import sci_pkg::*;
#(
    parameter int OVS   = 32,
    parameter int FLEN  = FRAME_MAX,
    parameter int NBW   = LEN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            load,
    input  logic [FLEN-1:0] frame,
    input  logic [NBW-1:0]  nbits,
    output logic            txd,
    output logic            busy,
    output logic            done
);
    localparam int CNT_W = $clog2(OVS);

    logic [FLEN-1:0]  sh_q;
    logic [NBW-1:0]   left_q;
    logic [CNT_W-1:0] sub_q;
    logic             bit_end;

    assign bit_end = tick && (sub_q == CNT_W'(OVS - 1));
    assign txd     = busy ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            left_q <= '0;
            sub_q  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (load) begin
                    sh_q   <= frame;
                    left_q <= nbits;
                    sub_q  <= '0;
                    busy   <= 1'b1;
                end
            end else if (tick) begin
                if (bit_end) begin
                    sub_q  <= '0;
                    sh_q   <= {1'b1, sh_q[FLEN-1:1]};
                    left_q <= left_q - 1'b1;
                    if (left_q == NBW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> (busy && !txd));

    assert_last_bit_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && bit_end && left_q == NBW'(1)) |-> txd);

endmodule

// File: rtl/sci_rx.sv
module sci_rx
    import sci_pkg::*;
#(
    parameter int OVS       = 32,
    parameter int SAMPLE_AT = 16,
    parameter int DW        = REG_W,
    parameter int NBW       = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          rxd,
    input  logic          seven,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          par_err,
    output logic          frm_err
);
    localparam int CNT_W  = $clog2(OVS);
    localparam int HOLD_W = DW + 1;                     // data bits plus parity

    logic [1:0]        sync_q;
    logic              line;
    logic              active;
    logic [CNT_W-1:0]  sub_q;
    logic [NBW-1:0]    idx_q;
    logic [HOLD_W-1:0] hold_q;
    logic [NBW-1:0]    stop_idx;
    logic [DW-1:0]     word;
    logic              par_bit;

    assign line = sync_q[1];

    always_comb begin
        stop_idx = NBW'(seven ? DW : DW + 1) + NBW'(par_en);
        word     = seven ? {1'b0, hold_q[DW-2:0]} : hold_q[DW-1:0];
        par_bit  = seven ? hold_q[DW-1] : hold_q[DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            active  <= 1'b0;
            sub_q   <= '0;
            idx_q   <= '0;
            hold_q  <= '0;
            done    <= 1'b0;
            data    <= '0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            done   <= 1'b0;
            if (!en) begin
                active <= 1'b0;
            end else if (!active) begin
                if (!line) begin
                    active <= 1'b1;
                    sub_q  <= '0;
                    idx_q  <= '0;
                end
            end else if (tick) begin
                sub_q <= (sub_q == CNT_W'(OVS - 1)) ? '0 : sub_q + 1'b1;
                if (sub_q == CNT_W'(SAMPLE_AT)) begin
                    if (idx_q == '0) begin
                        if (line) active <= 1'b0;       // glitch, not a start bit
                        idx_q <= idx_q + 1'b1;
                    end else if (idx_q == stop_idx) begin
                        active  <= 1'b0;
                        done    <= 1'b1;
                        data    <= word;
                        par_err <= par_en && (par_bit != parity_of(seven, par_odd, word));
                        frm_err <= !line;
                    end else begin
                        hold_q[idx_q - 1'b1] <= line;
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !done);

endmodule

// File: rtl/sci_uart_top.sv
module sci_uart_top
    import sci_pkg::*;
#(
    parameter int OVS       = 32,
    parameter int SAMPLE_AT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_tx_empty,
    output logic       irq_rx_full,
    output logic       irq_rx_err,
    output logic       irq_tx_done
);
    logic [REG_W-1:0] mode_q, rate_q, ctrl_q, tdat_q, rdat_q;
    logic             tx_empty, rx_full, ovr, fer, per, tx_fin;
    logic [REG_W-1:0] status;
    line_cfg_t        cfg;
    logic             tick, tx_load, tx_busy, tx_end;
    logic             rx_done, rx_perr, rx_ferr;
    logic [REG_W-1:0] rx_word;
    logic             wr_stat;
    logic [4:0]       clr;                               // status bits 7..3

    assign cfg     = '{seven: mode_q[6], par_en: mode_q[5], par_odd: mode_q[4],
                       two_stop: mode_q[3], div_sel: mode_q[1:0]};
    assign status  = {tx_empty, rx_full, ovr, fer, per, tx_fin, 2'b00};
    assign wr_stat = reg_wr && (reg_ofs_e'(reg_addr) == OFS_STAT);
    assign clr     = wr_stat ? ~reg_wdata[7:3] : '0;
    assign tx_load = ctrl_q[5] && !tx_empty && !tx_busy;

    sci_rate_gen #(.CNT_W(PRESC_W)) u_rate (
        .clk(clk), .rst(rst), .div_sel(cfg.div_sel), .rate(rate_q), .tick(tick)
    );

    sci_tx #(.OVS(OVS), .FLEN(FRAME_MAX), .NBW(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .load(tx_load),
        .frame(frame_of(cfg.seven, cfg.par_en, cfg.par_odd, tdat_q)),
        .nbits(frame_len(cfg.seven, cfg.par_en, cfg.two_stop)),
        .txd(txd), .busy(tx_busy), .done(tx_end)
    );

    sci_rx #(.OVS(OVS), .SAMPLE_AT(SAMPLE_AT), .DW(REG_W), .NBW(LEN_W)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl_q[4]), .rxd(rxd),
        .seven(cfg.seven), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
        .done(rx_done), .data(rx_word), .par_err(rx_perr), .frm_err(rx_ferr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            rate_q   <= '1;
            ctrl_q   <= '0;
            tdat_q   <= '1;
            rdat_q   <= '0;
            tx_empty <= STAT_RESET[7];
            rx_full  <= 1'b0;
            ovr      <= 1'b0;
            fer      <= 1'b0;
            per      <= 1'b0;
            tx_fin   <= STAT_RESET[2];
        end else begin
            if (reg_wr) begin
                case (reg_ofs_e'(reg_addr))
                    OFS_MODE: mode_q <= reg_wdata;
                    OFS_RATE: rate_q <= reg_wdata;
                    OFS_CTRL: ctrl_q <= reg_wdata;
                    OFS_TDAT: tdat_q <= reg_wdata;
                    default:  ;
                endcase
            end
            // transmit side
            if (tx_load)     tx_empty <= 1'b1;
            else if (clr[4]) tx_empty <= 1'b0;
            if (tx_load || clr[4])       tx_fin <= 1'b0;
            else if (tx_end && tx_empty) tx_fin <= 1'b1;
            // receive side: software clears first, hardware sets win
            if (clr[3]) rx_full <= 1'b0;
            if (clr[2]) ovr     <= 1'b0;
            if (clr[1]) fer     <= 1'b0;
            if (clr[0]) per     <= 1'b0;
            if (rx_done) begin
                if (rx_full) begin
                    ovr <= 1'b1;
                end else begin
                    rdat_q  <= rx_word;
                    rx_full <= 1'b1;
                    if (rx_perr) per <= 1'b1;
                    if (rx_ferr) fer <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (reg_ofs_e'(reg_addr))
            OFS_MODE: reg_rdata = mode_q;
            OFS_RATE: reg_rdata = rate_q;
            OFS_CTRL: reg_rdata = ctrl_q;
            OFS_TDAT: reg_rdata = tdat_q;
            OFS_STAT: reg_rdata = status;
            OFS_RDAT: reg_rdata = rdat_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_tx_empty = tx_empty && ctrl_q[7];
    assign irq_rx_full  = rx_full && ctrl_q[6];
    assign irq_rx_err   = (ovr || fer || per) && ctrl_q[6];
    assign irq_tx_done  = tx_fin && ctrl_q[2];

    assert_status_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (status == STAT_RESET));

    assert_refill_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (tx_empty && tx_busy));

    assert_end_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
        tx_fin |-> tx_empty);

    assert_overrun_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full) |=> (ovr && $stable(rdat_q)));

endmodule

// File: tb/sci_uart_top_tb_top.sv
module sci_uart_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sci_uart_top dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
        .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
        .irq_rx_err(irq_rx_err), .irq_tx_done(irq_tx_done)
    );

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] rate;
        logic [7:0] data;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h01, 8'hA5},    // 8N1, 32 clocks per bit
        '{8'h40, 8'h01, 8'h5A},    // 7N1
        '{8'h20, 8'h01, 8'h13},    // 8 even
        '{8'h30, 8'h01, 8'h13},    // 8 odd
        '{8'h68, 8'h02, 8'h7F},    // 7 even, 2 stop, 64 clocks per bit
        '{8'h01, 8'h01, 8'hC3},    // divider 4
        '{8'h3A, 8'h01, 8'h81}     // divider 16, odd, 2 stop
    };

    function automatic int nbits_of(input logic [7:0] m);
        return 1 + (m[6] ? 7 : 8) + (m[5] ? 1 : 0) + (m[3] ? 2 : 1);
    endfunction

    function automatic int bitclk_of(input logic [7:0] m, input logic [7:0] r);
        return 32 * (1 << (2 * int'(m[1:0]))) * int'(r);
    endfunction

    function automatic logic [11:0] model_frame(input logic [7:0] m, input logic [7:0] d);
        logic [11:0] f;
        logic p;
        int nd;
        f  = '1;
        f[0] = 1'b0;
        nd = m[6] ? 7 : 8;
        p  = m[4];
        for (int i = 0; i < nd; i++) begin
            f[1 + i] = d[i];
            p = p ^ d[i];
        end
        if (m[5]) f[1 + nd] = p;
        return f;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic grab_tx(input int n, input int bc, output logic [11:0] got);
        got = '1;
        while (txd === 1'b1) @(negedge clk);
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) repeat (bc) @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [11:0] f, input int n, input int bc);
        for (int i = 0; i < n; i++) begin
            rxd = f[i];
            repeat (bc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [11:0] got, f;
        logic [7:0]  last_rx;
        int          n, bc;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd(3'd0, v); check("R1", "mode reset", v, 8'h00);
        rd(3'd1, v); check("R1", "rate reset", v, 8'hFF);
        rd(3'd2, v); check("R1", "ctrl reset", v, 8'h00);
        rd(3'd3, v); check("R1", "tdat reset", v, 8'hFF);
        rd(3'd4, v); check("R1", "status reset", v, 8'h84);
        rd(3'd5, v); check("R1", "rdat reset", v, 8'h00);
        check("R1", "txd idle", txd, 1'b1);

        // R9: writing ones leaves status alone
        wr(3'd4, 8'hFF);
        rd(3'd4, v); check("R9", "write ones", v, 8'h84);

        // R4 / R5: transmitter disabled holds the byte
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h3C);
        wr(3'd4, 8'h00);
        repeat (100) @(negedge clk);
        check("R4", "txd while disabled", txd, 1'b1);
        rd(3'd4, v);
        check("R4", "empty stays clear", v[7], 1'b0);
        check("R5", "end cleared with empty", v[2], 1'b0);
        check("R10", "tx irq masked", irq_tx_empty, 1'b0);

        // enable transmitter plus tx-empty and tx-end interrupt enables
        wr(3'd2, 8'hA4);
        rd(3'd4, v);
        check("R4", "empty refilled", v[7], 1'b1);
        check("R10", "tx empty irq", irq_tx_empty, 1'b1);
        check("R10", "tx done irq low while sending", irq_tx_done, 1'b0);
        grab_tx(10, 32, got);
        check("R2", "frame 3C", got, model_frame(8'h00, 8'h3C));
        repeat (20) @(negedge clk);
        rd(3'd4, v);
        check("R5", "transmit end", v[2], 1'b1);
        check("R10", "tx done irq", irq_tx_done, 1'b1);

        // table: same byte out through txd and in through rxd
        last_rx = '0;
        for (int k = 0; k < NVEC; k++) begin
            n  = nbits_of(VECS[k].mode);
            bc = bitclk_of(VECS[k].mode, VECS[k].rate);
            f  = model_frame(VECS[k].mode, VECS[k].data);
            wr(3'd0, VECS[k].mode);
            wr(3'd1, VECS[k].rate);
            wr(3'd2, 8'h30);
            wr(3'd3, VECS[k].data);
            wr(3'd4, 8'h00);
            grab_tx(n, bc, got);
            check("R2 R3", $sformatf("tx frame vec %0d", k), got, f);
            repeat (bc / 2 + bc / 8) @(negedge clk);
            rd(3'd4, v);
            check("R5", $sformatf("end flag vec %0d", k), v[2], 1'b1);
            send_rx(f, n, bc);
            last_rx = VECS[k].mode[6] ? {1'b0, VECS[k].data[6:0]} : VECS[k].data;
            rd(3'd5, v);
            check("R6 R3", $sformatf("rx data vec %0d", k), v, last_rx);
            rd(3'd4, v);
            check("R6", $sformatf("rx flags vec %0d", k), v[6:3], 4'b1000);
        end

        // R6: receiver disabled ignores a frame
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h20);
        wr(3'd4, 8'h84);
        send_rx(model_frame(8'h00, 8'h55), 10, 32);
        rd(3'd4, v); check("R6", "full stays clear when off", v, 8'h84);
        rd(3'd5, v); check("R6", "rdat kept when off", v, last_rx);

        // R7: overrun
        wr(3'd2, 8'h70);
        send_rx(model_frame(8'h00, 8'h11), 10, 32);
        rd(3'd5, v); check("R6", "first byte", v, 8'h11);
        check("R10", "rx full irq", irq_rx_full, 1'b1);
        check("R10", "rx err irq low", irq_rx_err, 1'b0);
        send_rx(model_frame(8'h00, 8'h22), 10, 32);
        rd(3'd5, v); check("R7", "rdat not overwritten", v, 8'h11);
        rd(3'd4, v); check("R7", "overrun flag", v, 8'hE4);
        check("R10", "rx err irq", irq_rx_err, 1'b1);

        // R9: ones ignored, zero clears only its bit
        wr(3'd4, 8'hFF);
        rd(3'd4, v); check("R9", "ones ignored", v, 8'hE4);
        wr(3'd4, 8'hDF);
        rd(3'd4, v); check("R9", "overrun cleared alone", v, 8'hC4);

        // R8: parity mismatch
        wr(3'd4, 8'h84);
        wr(3'd0, 8'h20);
        f = model_frame(8'h20, 8'h0F);
        f[9] = ~f[9];
        send_rx(f, 11, 32);
        rd(3'd4, v); check("R8", "parity error flag", v[6:3], 4'b1001);
        rd(3'd5, v); check("R8", "data with parity error", v, 8'h0F);

        // R8: low stop bit
        wr(3'd4, 8'h84);
        wr(3'd0, 8'h00);
        f = model_frame(8'h00, 8'h99);
        f[9] = 1'b0;
        send_rx(f, 10, 32);
        repeat (64) @(negedge clk);
        rd(3'd4, v); check("R8", "framing error flag", v[6:3], 4'b1010);

        finish_run();
    end

endmodule